// File: doc/BRIEF.md
# Dual-Width Serial Host Link

This block is the slave side of a host microcontroller link for a display controller. The host opens a frame by raising a frame-sync line and then strobes a link clock. On every rising edge of that clock the block takes in one unit of data. A unit is a single bit on lane 0 in narrow mode, or a full nibble on lanes 3:0 in wide mode. Twelve-bit words are built from these units. The first word of a frame is an instruction that names a start address and a direction. Each word after it goes to, or comes from, the next address in turn.

The link width comes from a strap pin that is sampled only while reset is held. Writes leave the block on a valid/ready stream toward the register side. Reads go out as address requests on a second valid/ready stream, and the fetched word comes back on a plain response strobe. The block then drives the word onto the link lanes in the same unit order it uses for input. A level interrupt output is set by an internal event pulse. The host clears it by writing to a reserved address.

The host link itself cannot be stalled. Back-pressure rules: the write slot is one entry deep. An offered write keeps its address and data stable until ready is seen. The register side must accept each write before the next write word completes. A read request holds its address until it is accepted, unless the frame closes first. The response must arrive before the host's next rising link-clock edge.

Top module: `shi_host_link`

## Requirements
- R1: After reset, `lnk_irq`, `lnk_oe`, `wr_valid` and `rd_valid` are all 0.
- R2: `strap_n` is sampled only while `rst_n` is low. Low selects wide (4-bit) mode and high selects narrow (1-bit) mode. Changes to the strap after reset do not change the mode.
- R3: In narrow mode a word takes 12 rising link-clock edges. Only lane 0 is used, with word bit 0 first. Lanes 3:1 are ignored.
- R4: In wide mode a word takes 3 rising edges. The first nibble is bits 3:0, then bits 7:4, then bits 11:8. Lane i carries bit i of each nibble.
- R5: In the first word of a frame, bit 11 set means a read and bit 11 clear means a write. Bits 7:0 give the start address. Bits 10:8 are ignored.
- R6: In a write frame, each later word is emitted as `wr_addr`/`wr_data`. The address starts at the start address and increases by one per word, wrapping modulo 256.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R8: In a read frame, the block requests each address in turn on `rd_valid`/`rd_addr`, starting at the start address and incrementing. It then drives the returned word out in the same unit order as R3/R4. Output enable covers lane 0 only in narrow mode and all four lanes in wide mode.
- R9: When frame sync is low, link-clock edges have no effect and `lnk_oe` is 0 from the next cycle on. A partly received word is discarded when the frame closes.
- R10: An `evt_pulse` sets `lnk_irq` on the next cycle. A write to address 0xFF clears it, and that write is not emitted on the write stream. If both happen in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all link inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_n | input | 1 | Width strap: low = 4-bit, high = 1-bit |
| lnk_fs | input | 1 | Frame sync from host, high while a frame is open |
| lnk_ck | input | 1 | Link clock from host, units taken on rising edges |
| lnk_din | input | 4 | Link data lanes from host |
| lnk_dout | output | 4 | Read data lanes toward host |
| lnk_oe | output | 4 | Per-lane output enable for `lnk_dout` |
| lnk_irq | output | 1 | Level interrupt request to host |
| evt_pulse | input | 1 | Internal event that raises the interrupt |
| wr_valid | output | 1 | Write stream valid |
| wr_ready | input | 1 | Write stream ready |
| wr_addr | output | 8 | Write address |
| wr_data | output | 12 | Write data |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request ready |
| rd_addr | output | 8 | Read request address |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 12 | Read response word |

## Verification
The assertions assume a few things about the inputs. The link signals are synchronous to `clk`. Frame sync never rises in the same cycle as a link-clock edge. No link-clock edge arrives while a read fetch is still outstanding. The register side drains a write before the next write word completes. The bench keeps within these limits by holding each link-clock phase for four block cycles, which leaves room for a fetch. The register side it models answers reads one cycle after accepting them, and it drops ready for at most two cycles in a row. It changes frame sync only while the link clock is low.

// File: rtl/shi_pkg.sv
package shi_pkg;
  localparam int LANE_N = 4;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RD_SHIFT
  } link_st_e;
endpackage

// File: rtl/shi_link_sense.sv
module shi_link_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic lnk_fs,
  input  logic lnk_ck,
  output logic fs_rise,
  output logic ck_rise
);
  logic fs_q, ck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      ck_q <= 1'b0;
    end else begin
      fs_q <= lnk_fs;
      ck_q <= lnk_ck;
    end
  end

  assign fs_rise = lnk_fs & ~fs_q;
  assign ck_rise = lnk_ck & ~ck_q & lnk_fs;
endmodule

// File: rtl/shi_deser.sv
module shi_deser import shi_pkg::*; #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              clr,
  input  logic              en,
  input  logic [LANE_N-1:0] din,
  output logic [WORD_W-1:0] word,
  output logic              done
);
  localparam int NARROW_UNITS = WORD_W;
  localparam int WIDE_UNITS   = WORD_W / LANE_N;
  localparam int CNT_W        = $clog2(NARROW_UNITS + 1);

  logic [WORD_W-1:0] acc, acc_nx;
  logic [CNT_W-1:0]  cnt;
  logic              last;

  assign last = (cnt == (wide ? CNT_W'(WIDE_UNITS - 1) : CNT_W'(NARROW_UNITS - 1)));

  always_comb begin
    if (wide) acc_nx = {din, acc[WORD_W-1:LANE_N]};
    else      acc_nx = {din[0], acc[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (en) begin
        acc <= acc_nx;
        if (last) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign word = acc;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < (wide ? CNT_W'(WIDE_UNITS) : CNT_W'(NARROW_UNITS))));
endmodule

// File: rtl/shi_ser.sv
module shi_ser import shi_pkg::*; #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              load,
  input  logic [WORD_W-1:0] ldata,
  input  logic              shift,
  output logic [LANE_N-1:0] dout,
  output logic              last
);
  localparam int NARROW_UNITS = WORD_W;
  localparam int WIDE_UNITS   = WORD_W / LANE_N;
  localparam int CNT_W        = $clog2(NARROW_UNITS + 1);

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  assign last = (cnt == (wide ? CNT_W'(WIDE_UNITS - 1) : CNT_W'(NARROW_UNITS - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= ldata;
      cnt <= '0;
    end else if (shift) begin
      sr  <= wide ? (sr >> LANE_N) : (sr >> 1);
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign dout = wide ? sr[LANE_N-1:0] : {{(LANE_N-1){1'b0}}, sr[0]};

  // R4
  ser_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < (wide ? CNT_W'(WIDE_UNITS) : CNT_W'(NARROW_UNITS))));
endmodule

// File: rtl/shi_irq.sv
module shi_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (evt) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq);
  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !irq);
endmodule

// File: rtl/shi_host_link.sv
module shi_host_link import shi_pkg::*; #(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 8,
  parameter int RD_FLAG_BIT = 11,
  parameter logic [ADDR_W-1:0] IRQ_CLR_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_n,
  input  logic              lnk_fs,
  input  logic              lnk_ck,
  input  logic [LANE_N-1:0] lnk_din,
  output logic [LANE_N-1:0] lnk_dout,
  output logic [LANE_N-1:0] lnk_oe,
  output logic              lnk_irq,
  input  logic              evt_pulse,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data
);
  localparam logic [LANE_N-1:0] OE_WIDE   = '1;
  localparam logic [LANE_N-1:0] OE_NARROW = LANE_N'(1);

  link_st_e          state;
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fs_rise, ck_rise;
  logic              collect, dz_clr, dz_done;
  logic [WORD_W-1:0] dz_word;
  logic              sr_load, sr_shift, sr_last;
  logic [LANE_N-1:0] sr_dout;
  logic              push, irq_clr;
  logic              wv_q;
  logic [ADDR_W-1:0] wa_q;
  logic [WORD_W-1:0] wd_q;

  shi_link_sense u_sense (
    .clk(clk), .rst_n(rst_n), .lnk_fs(lnk_fs), .lnk_ck(lnk_ck),
    .fs_rise(fs_rise), .ck_rise(ck_rise)
  );

  assign collect = (state == ST_CMD) || (state == ST_WR);
  assign dz_clr  = (state == ST_IDLE) || !lnk_fs;

  shi_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .wide(wide_q), .clr(dz_clr),
    .en(ck_rise && collect), .din(lnk_din), .word(dz_word), .done(dz_done)
  );

  assign sr_load  = (state == ST_RD_WAIT) && rsp_valid;
  assign sr_shift = (state == ST_RD_SHIFT) && ck_rise;

  shi_ser #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .wide(wide_q), .load(sr_load),
    .ldata(rsp_data), .shift(sr_shift), .dout(sr_dout), .last(sr_last)
  );

  assign push    = (state == ST_WR) && dz_done && (addr_q != IRQ_CLR_ADDR);
  assign irq_clr = (state == ST_WR) && dz_done && (addr_q == IRQ_CLR_ADDR);

  shi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(irq_clr), .irq(lnk_irq)
  );

  // width strap is only captured while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= !strap_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
    end else if (!lnk_fs) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (fs_rise) state <= ST_CMD;
        ST_CMD: if (dz_done) begin
          addr_q <= dz_word[ADDR_W-1:0];
          state  <= dz_word[RD_FLAG_BIT] ? ST_RD_REQ : ST_WR;
        end
        ST_WR: if (dz_done) addr_q <= addr_q + 1'b1;
        ST_RD_REQ: if (rd_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) state <= ST_RD_SHIFT;
        ST_RD_SHIFT: if (ck_rise && sr_last) begin
          addr_q <= addr_q + 1'b1;
          state  <= ST_RD_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // one-deep write slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
    end else if (push) begin
      wv_q <= 1'b1;
      wa_q <= addr_q;
      wd_q <= dz_word;
    end else if (wr_ready) begin
      wv_q <= 1'b0;
    end
  end

  assign wr_valid = wv_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
  assign rd_valid = (state == ST_RD_REQ);
  assign rd_addr  = addr_q;
  assign lnk_oe   = (state == ST_RD_SHIFT) ? (wide_q ? OE_WIDE : OE_NARROW) : '0;
  assign lnk_dout = sr_dout & lnk_oe;

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!wr_valid || wr_ready));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && lnk_fs) |=> (rd_valid && $stable(rd_addr)));
  // R8
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD_REQ) || (state == ST_RD_WAIT)) |-> !ck_rise);
  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_fs |=> (lnk_oe == '0));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(wide_q));
endmodule

// File: tb/tb_shi_host_link.sv
`timescale 1ns/1ps
module tb_shi_host_link;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_n = 1'b1;
  logic lnk_fs = 1'b0, lnk_ck = 1'b0;
  logic [3:0] lnk_din = '0;
  logic [3:0] lnk_dout, lnk_oe;
  logic lnk_irq, evt_pulse = 1'b0;
  logic wr_valid, wr_ready = 1'b1;
  logic [7:0] wr_addr, rd_addr;
  logic [11:0] wr_data, rsp_data = '0;
  logic rd_valid, rd_ready = 1'b1, rsp_valid = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  logic tb_wide;
  logic [7:0] qa [0:63];
  logic [11:0] qd [0:63];
  int qn = 0;
  logic pend = 1'b0;
  logic [7:0] pend_a = '0;

  always #2.5 clk = ~clk;

  shi_host_link dut (
    .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .lnk_fs(lnk_fs), .lnk_ck(lnk_ck),
    .lnk_din(lnk_din), .lnk_dout(lnk_dout), .lnk_oe(lnk_oe), .lnk_irq(lnk_irq),
    .evt_pulse(evt_pulse), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [11:0] rf(input logic [7:0] a);
    return 12'((int'(a) * 37 + 5) & 12'hfff);
  endfunction

  function automatic logic [11:0] dval(input logic [7:0] s, input int i);
    return 12'((int'(s) * 7 + i * 291 + 13) & 12'hfff);
  endfunction

  // register-side model: stalls ready, answers reads one cycle after acceptance
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    if (pend) begin
      rsp_valid = 1'b1;
      rsp_data  = rf(pend_a);
      pend = 1'b0;
    end
    rd_ready = (cyc % 3) != 0;
    wr_ready = (cyc % 4) != 1;
    if (rd_valid && rd_ready) begin
      pend = 1'b1;
      pend_a = rd_addr;
    end
    if (wr_valid && wr_ready && qn < 64) begin
      qa[qn] = wr_addr;
      qd[qn] = wr_data;
      qn++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unit_out(input logic [3:0] v);
    lnk_din = v;
    tick(HP);
    lnk_ck = 1'b1;
    tick(HP);
    lnk_ck = 1'b0;
  endtask

  task automatic send_word(input logic [11:0] w);
    if (tb_wide) begin
      for (int u = 0; u < 3; u++) unit_out(w[4*u +: 4]);
    end else begin
      for (int u = 0; u < 12; u++) unit_out({3'b101, w[u]});
    end
  endtask

  task automatic recv_word(input logic [11:0] exp, input string req);
    logic [11:0] got;
    got = '0;
    for (int u = 0; u < (tb_wide ? 3 : 12); u++) begin
      tick(HP);
      if (u == 0) chk(lnk_oe == (tb_wide ? 4'hf : 4'h1), "R8 oe", lnk_oe, tb_wide ? 4'hf : 4'h1);
      if (tb_wide) got[4*u +: 4] = lnk_dout;
      else got[u] = lnk_dout[0];
      lnk_ck = 1'b1;
      tick(HP);
      lnk_ck = 1'b0;
    end
    chk(got == exp, req, got, exp);
  endtask

  task automatic open_frame();
    lnk_fs = 1'b1;
    tick(2);
  endtask

  task automatic close_frame();
    tick(2);
    lnk_fs = 1'b0;
    tick(12);
  endtask

  task automatic do_reset(input logic wide);
    tb_wide = wide;
    strap_n = !wide;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(!lnk_irq && lnk_oe == 0 && !wr_valid && !rd_valid, "R1 reset",
        {lnk_irq, lnk_oe, wr_valid, rd_valid}, 0);
    // R2: flipping the strap after reset must not change the width
    strap_n = wide;
  endtask

  task automatic do_write(input logic [7:0] s, input int n);
    int k;
    qn = 0;
    open_frame();
    send_word({1'b0, 3'b101, s});   // R5: bits 10:8 ignored
    for (int i = 0; i < n; i++) send_word(dval(s, i));
    close_frame();
    k = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = 8'(int'(s) + i);
      if (a != 8'hff) begin
        if (k < qn) begin
          chk(qa[k] == a, "R6 addr", qa[k], a);
          chk(qd[k] == dval(s, i), tb_wide ? "R4 data" : "R3 data", qd[k], dval(s, i));
        end
        k++;
      end
    end
    chk(qn == k, "R6 count", qn, k);
  endtask

  task automatic do_read(input logic [7:0] s, input int n);
    open_frame();
    send_word({1'b1, 3'b011, s});
    for (int i = 0; i < n; i++) recv_word(rf(8'(int'(s) + i)), "R8 data");
    close_frame();
    chk(lnk_oe == 0, "R9 oe after close", lnk_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      // R3 / R4 / R6 write sweeps, including wrap through the clear address
      do_write(8'h00, 1);
      do_write(8'h5a, 2);
      do_write(8'h30, 3);
      do_write(8'hfd, 4);
      // R8 read sweeps
      do_read(8'h00, 1);
      do_read(8'h7f, 2);
      do_read(8'hfe, 3);
      // R10 set then clear through address 0xFF
      evt_pulse = 1'b1;
      tick(1);
      evt_pulse = 1'b0;
      chk(lnk_irq, "R10 set", lnk_irq, 1);
      do_write(8'hff, 1);
      chk(!lnk_irq, "R10 clear", lnk_irq, 0);
      // R9 clock edges with frame sync low do nothing
      qn = 0;
      for (int i = 0; i < 14; i++) unit_out(4'hf);
      tick(6);
      chk(qn == 0 && lnk_oe == 0, "R9 idle clock", qn, 0);
      // R9 partial word dropped when the frame closes
      qn = 0;
      open_frame();
      send_word(12'h010);
      unit_out(4'h3);
      close_frame();
      chk(qn == 0, "R9 partial", qn, 0);
      do_write(8'h10, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule